// File: doc/BRIEF.md
# Programmable LCD Timing Generator

The block drives a parallel RGB panel. From a single core clock it produces horizontal sync, vertical sync, a data-enable strobe and the column and row of the current active pixel. Software programs the porch, sync and active lengths for both axes through a small write-only register port. Every length is stored as its count minus one. An optional divider slows the pixel rate to one pixel every N core cycles. A separate bit bypasses the divider, so pixels advance on every core cycle.

Each axis is a four-state machine that walks SEG_SYNC, SEG_BACK, SEG_ACTIVE and SEG_FRONT in that order, then wraps to SEG_SYNC. The horizontal machine steps on each pixel enable and moves to the next state when its counter reaches the programmed limit. The vertical machine steps once per line, on the horizontal wrap from SEG_FRONT to SEG_SYNC.

Two bits gate the visible output. A run bit starts the counters. A frame-enable bit lets sync and data-enable show, and it is sampled only when a frame begins. The first pixel of every frame raises a sticky interrupt-pending flag, provided the interrupt is enabled. Software clears the flag by writing a one to it.

Top module: `lcd_timing_gen`

## Requirements
- R1: A line is sync, back porch, active, front porch, in that order. Each segment lasts its field plus one pixel periods. The fields are the register at address 1: bits [7:0] sync, [15:8] back, [23:16] front.
- R2: A frame is built from lines in the same four-segment order. The vertical fields are the register at address 2, with the same bit layout as address 1.
- R3: The active width is field plus one, from address 3 bits [10:0]. The active height is field plus one, from address 3 bits [26:16]. `de_o` is high only when both axes are in their active segment.
- R4: While `de_o` is high, `px_x` and `px_y` give the zero-based column and row inside the active area. Outside it they read 0.
- R5: Address 0 bit 2 set makes each pixel last (bits [15:8] + 1) core cycles. With bit 2 clear, one pixel passes per core cycle whatever bits [15:8] hold.
- R6: Address 0 bit 3 inverts `hsync_o` and bit 4 inverts `vsync_o`. The uninverted sync is active high.
- R7: While address 0 bit 0 (run) is clear, both machines are held in SEG_SYNC with count 0 and `de_o` is low. After run is set, the first pixel is the first sync pixel of a frame.
- R8: Address 0 bit 1 (frame enable) is sampled only at the first pixel of a frame. While the sampled value is 0, both syncs sit at their inactive level and `de_o` is low.
- R9: At the first pixel of a frame, the pending flag is set when address 4 bit 0 (global enable) and bit 1 (frame enable) are both 1 and bits [3:2] equal 0 (vertical-sync source).
- R10: Writing address 5 with bit 0 = 1 clears the pending flag. Writing 0 there leaves it unchanged, and a set in the same cycle wins.
- R11: `irq_o` is high exactly when the flag is pending and both enables at address 4 are set.
- R12: After reset all registers are 0, both syncs and `de_o` are low, and no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | AW | register address |
| reg_wdata | input | 32 | register write data |
| hsync_o | output | 1 | horizontal sync after polarity |
| vsync_o | output | 1 | vertical sync after polarity |
| de_o | output | 1 | data enable |
| px_x | output | SW | active column |
| px_y | output | SW | active row |
| irq_o | output | 1 | gated frame interrupt |
| irq_pend_o | output | 1 | sticky pending flag |

## Verification
The pixel outputs decode the state registers directly, so the first pixel appears in the cycle after the edge that sets run. The monitor starts comparing at the falling edge of that cycle and pops one expected item per core cycle. With the divider on, each pixel is expanded into N identical items. The pending flag is registered one edge after the first pixel, and the bench reads it three edges after run rises. A clear write shows on the flag one cycle after the strobe, and the bench checks it just after that edge. The frame-enable write made mid-frame is covered by the stream itself: its expected items stay blank until the next frame's first pixel.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC   = 2'd0,
        SEG_BACK   = 2'd1,
        SEG_ACTIVE = 2'd2,
        SEG_FRONT  = 2'd3
    } seg_t;

    localparam logic [2:0] ADR_CTRL   = 3'd0;
    localparam logic [2:0] ADR_HTIM   = 3'd1;
    localparam logic [2:0] ADR_VTIM   = 3'd2;
    localparam logic [2:0] ADR_SIZE   = 3'd3;
    localparam logic [2:0] ADR_IRQCFG = 3'd4;
    localparam logic [2:0] ADR_IRQCLR = 3'd5;

    localparam logic [1:0] SRC_VSYNC = 2'd0;
endpackage

// File: rtl/lcdtg_regs.sv
module lcdtg_regs
    import lcdtg_pkg::*;
#(
    parameter int AW = 3,
    parameter int PW = 8,
    parameter int SW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic          run,
    output logic          frame_en,
    output logic          div_en,
    output logic          hs_inv,
    output logic          vs_inv,
    output logic [DW-1:0] div_val,
    output logic [PW-1:0] h_sync,
    output logic [PW-1:0] h_back,
    output logic [PW-1:0] h_front,
    output logic [PW-1:0] v_sync,
    output logic [PW-1:0] v_back,
    output logic [PW-1:0] v_front,
    output logic [SW-1:0] h_act,
    output logic [SW-1:0] v_act,
    output logic          gie,
    output logic          fie,
    output logic [1:0]    src,
    output logic          clr_pulse
);
    localparam int F1 = 8;
    localparam int F2 = 16;

    logic [2:0] a3;
    assign a3 = 3'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0; frame_en <= 1'b0; div_en <= 1'b0;
            hs_inv <= 1'b0; vs_inv <= 1'b0; div_val <= '0;
            h_sync <= '0; h_back <= '0; h_front <= '0;
            v_sync <= '0; v_back <= '0; v_front <= '0;
            h_act <= '0; v_act <= '0;
            gie <= 1'b0; fie <= 1'b0; src <= '0;
        end else if (we) begin
            unique case (a3)
                ADR_CTRL: begin
                    run      <= wdata[0];
                    frame_en <= wdata[1];
                    div_en   <= wdata[2];
                    hs_inv   <= wdata[3];
                    vs_inv   <= wdata[4];
                    div_val  <= wdata[F1 +: DW];
                end
                ADR_HTIM: begin
                    h_sync  <= wdata[0 +: PW];
                    h_back  <= wdata[F1 +: PW];
                    h_front <= wdata[F2 +: PW];
                end
                ADR_VTIM: begin
                    v_sync  <= wdata[0 +: PW];
                    v_back  <= wdata[F1 +: PW];
                    v_front <= wdata[F2 +: PW];
                end
                ADR_SIZE: begin
                    h_act <= wdata[0 +: SW];
                    v_act <= wdata[F2 +: SW];
                end
                ADR_IRQCFG: begin
                    gie <= wdata[0];
                    fie <= wdata[1];
                    src <= wdata[3:2];
                end
                default: ;
            endcase
        end
    end

    assign clr_pulse = we && (a3 == ADR_IRQCLR) && wdata[0];
endmodule

// File: rtl/lcdtg_clkdiv.sv
module lcdtg_clkdiv #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          div_en,
    input  logic [DW-1:0] div_val,
    output logic          pe
);
    logic [DW-1:0] cnt_q;
    logic          hit;

    assign hit = (cnt_q == div_val);
    assign pe  = !div_en || hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!run || !div_en) cnt_q <= '0;
        else if (hit)             cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/lcdtg_axis.sv
module lcdtg_axis
    import lcdtg_pkg::*;
#(
    parameter int SW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [SW-1:0] lim_sync,
    input  logic [SW-1:0] lim_back,
    input  logic [SW-1:0] lim_act,
    input  logic [SW-1:0] lim_front,
    output seg_t          seg,
    output logic [SW-1:0] cnt,
    output logic          wrap
);
    seg_t          seg_q, seg_d, seg_after;
    logic [SW-1:0] cnt_q, cnt_d, lim;
    logic          last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= SEG_SYNC;
            cnt_q <= '0;
        end else if (!run) begin
            seg_q <= SEG_SYNC;
            cnt_q <= '0;
        end else begin
            seg_q <= seg_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        unique case (seg_q)
            SEG_SYNC:   begin lim = lim_sync;  seg_after = SEG_BACK;   end
            SEG_BACK:   begin lim = lim_back;  seg_after = SEG_ACTIVE; end
            SEG_ACTIVE: begin lim = lim_act;   seg_after = SEG_FRONT;  end
            SEG_FRONT:  begin lim = lim_front; seg_after = SEG_SYNC;   end
            default:    begin lim = lim_sync;  seg_after = SEG_SYNC;   end
        endcase
        last  = (cnt_q == lim);
        seg_d = seg_q;
        cnt_d = cnt_q;
        if (step) begin
            if (last) begin
                seg_d = seg_after;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    assign seg  = seg_q;
    assign cnt  = cnt_q;
    assign wrap = step && last && (seg_q == SEG_FRONT);
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdtg_pkg::*;
#(
    parameter int AW = 3,
    parameter int PW = 8,
    parameter int SW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [SW-1:0] px_x,
    output logic [SW-1:0] px_y,
    output logic          irq_o,
    output logic          irq_pend_o
);
    localparam int PAD = SW - PW;

    logic          run, frame_en, div_en, hs_inv, vs_inv;
    logic [DW-1:0] div_val;
    logic [PW-1:0] h_sync, h_back, h_front, v_sync, v_back, v_front;
    logic [SW-1:0] h_act, v_act;
    logic          gie, fie, clr_pulse;
    logic [1:0]    src;

    lcdtg_regs #(.AW(AW), .PW(PW), .SW(SW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .run(run), .frame_en(frame_en), .div_en(div_en), .hs_inv(hs_inv), .vs_inv(vs_inv),
        .div_val(div_val), .h_sync(h_sync), .h_back(h_back), .h_front(h_front),
        .v_sync(v_sync), .v_back(v_back), .v_front(v_front), .h_act(h_act), .v_act(v_act),
        .gie(gie), .fie(fie), .src(src), .clr_pulse(clr_pulse)
    );

    logic pe;
    lcdtg_clkdiv #(.DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div_en(div_en), .div_val(div_val), .pe(pe)
    );

    seg_t          h_seg, v_seg;
    logic [SW-1:0] h_cnt, v_cnt;
    logic          h_wrap, v_wrap;

    lcdtg_axis #(.SW(SW)) u_hax (
        .clk(clk), .rst_n(rst_n), .run(run), .step(pe),
        .lim_sync({{PAD{1'b0}}, h_sync}), .lim_back({{PAD{1'b0}}, h_back}),
        .lim_act(h_act), .lim_front({{PAD{1'b0}}, h_front}),
        .seg(h_seg), .cnt(h_cnt), .wrap(h_wrap)
    );

    lcdtg_axis #(.SW(SW)) u_vax (
        .clk(clk), .rst_n(rst_n), .run(run), .step(h_wrap),
        .lim_sync({{PAD{1'b0}}, v_sync}), .lim_back({{PAD{1'b0}}, v_back}),
        .lim_act(v_act), .lim_front({{PAD{1'b0}}, v_front}),
        .seg(v_seg), .cnt(v_cnt), .wrap(v_wrap)
    );

    // first pixel of a frame (held for all core cycles of that pixel)
    logic at_start, live_q, live_eff, pend_q, hs_raw, vs_raw, de_int;

    assign at_start = run && (h_seg == SEG_SYNC) && (h_cnt == '0)
                          && (v_seg == SEG_SYNC) && (v_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        live_q <= 1'b0;
        else if (!run)     live_q <= 1'b0;
        else if (at_start) live_q <= frame_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                               pend_q <= 1'b0;
        else if (at_start && pe && gie && fie && src == SRC_VSYNC) pend_q <= 1'b1;
        else if (clr_pulse)                                       pend_q <= 1'b0;
    end

    always_comb begin
        live_eff   = at_start ? frame_en : live_q;
        hs_raw     = live_eff && (h_seg == SEG_SYNC);
        vs_raw     = live_eff && (v_seg == SEG_SYNC);
        de_int     = live_eff && (h_seg == SEG_ACTIVE) && (v_seg == SEG_ACTIVE);
        hsync_o    = hs_raw ^ hs_inv;
        vsync_o    = vs_raw ^ vs_inv;
        de_o       = de_int;
        px_x       = de_int ? h_cnt : '0;
        px_y       = de_int ? v_cnt : '0;
        irq_pend_o = pend_q;
        irq_o      = pend_q && gie && fie;
    end
endmodule

// File: rtl/lcdtg_chk.sv
module lcdtg_chk
    import lcdtg_pkg::*;
#(
    parameter int SW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          div_en,
    input logic          pe,
    input logic          de,
    input logic          hs_raw,
    input logic          vs_raw,
    input logic          at_start,
    input logic          live_q,
    input logic          pend,
    input logic          clr_pulse,
    input logic          gie,
    input logic          fie,
    input logic          irq,
    input logic [SW-1:0] px_x,
    input logic [SW-1:0] px_y,
    input logic [SW-1:0] h_act,
    input logic [SW-1:0] v_act,
    input seg_t          h_seg,
    input logic [SW-1:0] h_cnt
);
    a_r5_bypass_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !div_en |-> pe);
    a_r3_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hs_raw && !vs_raw));
    a_r4_coord_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (px_x <= h_act && px_y <= v_act));
    a_r7_start_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (h_seg == SEG_SYNC && h_cnt == '0));
    a_r8_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !at_start) |=> (live_q == $past(live_q)));
    a_r10_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr_pulse) |=> pend);
    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend && gie && fie));
endmodule

bind lcd_timing_gen lcdtg_chk #(.SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .div_en(div_en), .pe(pe), .de(de_o),
    .hs_raw(hs_raw), .vs_raw(vs_raw), .at_start(at_start), .live_q(live_q),
    .pend(pend_q), .clr_pulse(clr_pulse), .gie(gie), .fie(fie), .irq(irq_o),
    .px_x(px_x), .px_y(px_y), .h_act(h_act), .v_act(v_act), .h_seg(h_seg), .h_cnt(h_cnt)
);

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          hsync_o, vsync_o, de_o, irq_o, irq_pend_o;
    logic [SW-1:0] px_x, px_y;

    lcd_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .px_x(px_x), .px_y(px_y), .irq_o(irq_o), .irq_pend_o(irq_pend_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic          hs;
        logic          vs;
        logic          de;
        logic [SW-1:0] x;
        logic [SW-1:0] y;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    logic  mon_on = 1'b0;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog R1 run hung: got timeout, exp completion");
        summary();
    end

    // monitor: one expected item per core cycle while armed
    always @(negedge clk) begin
        if (mon_on && q.size() > 0) begin
            item_t e, g;
            e = q.pop_front();
            g = '{hs: hsync_o, vs: vsync_o, de: de_o, x: px_x, y: px_y};
            n_chk++;
            if (g !== e) begin
                n_fail++;
                $display("FAIL R1 R2 R3 R4 R5 R6 R7 R8 stream: got hs=%0b vs=%0b de=%0b x=%0d y=%0d exp hs=%0b vs=%0b de=%0b x=%0d y=%0d",
                         g.hs, g.vs, g.de, g.x, g.y, e.hs, e.vs, e.de, e.x, e.y);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    // driver: expected frames built from the segment order in the requirements
    task automatic push_frames(input int hl0, hl1, hl2, hl3, vl0, vl1, vl2, vl3,
                               input int rep, input bit hinv, vinv, live);
        for (int vs_i = 0; vs_i < 4; vs_i++) begin
            int vn = (vs_i == 0) ? vl0 : (vs_i == 1) ? vl1 : (vs_i == 2) ? vl2 : vl3;
            for (int vi = 0; vi < vn; vi++) begin
                for (int hs_i = 0; hs_i < 4; hs_i++) begin
                    int hn = (hs_i == 0) ? hl0 : (hs_i == 1) ? hl1 : (hs_i == 2) ? hl2 : hl3;
                    for (int hi = 0; hi < hn; hi++) begin
                        for (int r = 0; r < rep; r++) begin
                            item_t it;
                            it.hs = (live && hs_i == 0) ^ hinv;
                            it.vs = (live && vs_i == 0) ^ vinv;
                            it.de = live && hs_i == 2 && vs_i == 2;
                            it.x  = it.de ? SW'(hi) : '0;
                            it.y  = it.de ? SW'(vi) : '0;
                            q.push_back(it);
                        end
                    end
                end
            end
        end
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        #1 mon_on = 1'b0;
    endtask

    task automatic cfg_a();
        wr(3'd1, 32'h0001_0201);   // h: sync 2, back 3, front 2
        wr(3'd2, 32'h0000_0100);   // v: sync 1, back 2, front 1
        wr(3'd3, 32'h0002_0004);   // 5 x 3 active
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 hsync", 32'(hsync_o), 0);
        chk("R12 vsync", 32'(vsync_o), 0);
        chk("R12 de", 32'(de_o), 0);
        chk("R12 irq", 32'(irq_o), 0);
        chk("R12 pend", 32'(irq_pend_o), 0);

        // A: 1:1 with a nonzero divide value ignored (R5), two frames (R1 R2 R3 R4 R7)
        cfg_a();
        push_frames(2, 3, 5, 2, 1, 2, 3, 1, 1, 0, 0, 1);
        push_frames(2, 3, 5, 2, 1, 2, 3, 1, 1, 0, 0, 1);
        wr(3'd0, 32'h0000_0503);
        mon_on = 1'b1;
        drain();
        wr(3'd0, 32'h0000_0502);

        // B: divide by 3, both polarities inverted (R5 R6)
        wr(3'd1, 32'h0001_0000);
        wr(3'd2, 32'h0000_0001);
        wr(3'd3, 32'h0001_0002);
        push_frames(1, 1, 3, 2, 2, 1, 2, 1, 3, 1, 1, 1);
        wr(3'd0, 32'h0000_021F);
        mon_on = 1'b1;
        drain();
        wr(3'd0, 32'h0000_021E);
        repeat (2) @(posedge clk);
        #1;
        // R7 stopped: inactive levels under inversion
        chk("R7 idle hsync", 32'(hsync_o), 1);
        chk("R7 idle vsync", 32'(vsync_o), 1);
        chk("R7 idle de", 32'(de_o), 0);

        // C: frame enable written mid-frame takes effect next frame (R8)
        cfg_a();
        push_frames(2, 3, 5, 2, 1, 2, 3, 1, 1, 0, 0, 0);
        push_frames(2, 3, 5, 2, 1, 2, 3, 1, 1, 0, 0, 1);
        wr(3'd0, 32'h0000_0001);
        mon_on = 1'b1;
        repeat (20) @(posedge clk);
        wr(3'd0, 32'h0000_0003);
        drain();
        wr(3'd0, 32'h0000_0000);

        // D: interrupt pending, clear and gating (R9 R10 R11)
        wr(3'd4, 32'h0000_0003);
        wr(3'd0, 32'h0000_0003);
        repeat (3) @(posedge clk);
        #1;
        chk("R9 pend set at frame start", 32'(irq_pend_o), 1);
        chk("R11 irq with both enables", 32'(irq_o), 1);
        wr(3'd5, 32'h0000_0000);
        chk("R10 write 0 keeps pend", 32'(irq_pend_o), 1);
        wr(3'd4, 32'h0000_0002);
        chk("R11 irq masked by global enable", 32'(irq_o), 0);
        chk("R11 pend kept while masked", 32'(irq_pend_o), 1);
        wr(3'd5, 32'h0000_0001);
        chk("R10 write 1 clears pend", 32'(irq_pend_o), 0);
        wr(3'd0, 32'h0000_0000);

        wr(3'd4, 32'h0000_0001);
        wr(3'd0, 32'h0000_0003);
        repeat (3) @(posedge clk);
        #1;
        chk("R9 no pend with frame irq off", 32'(irq_pend_o), 0);
        wr(3'd0, 32'h0000_0000);

        wr(3'd4, 32'h0000_0007);
        wr(3'd0, 32'h0000_0003);
        repeat (3) @(posedge clk);
        #1;
        chk("R9 no pend with other source", 32'(irq_pend_o), 0);
        chk("R11 no irq with other source", 32'(irq_o), 0);
        wr(3'd0, 32'h0000_0000);

        summary();
    end
endmodule